// File: doc/BRIEF.md
# Double-Buffered DAC Channel Register

This block is the digital front end for a group of converter channels. Each channel owns two registers. The first is a staging register that can be filled from a narrow parallel bus. That bus carries a whole word, one byte or one nibble per transfer. The staging register can also be filled one bit per clock through a shift path. The second is the output register that drives the converter. It changes only when the shared commit strobe is pulsed.

The commit strobe copies every channel's staging register into its output register on the same clock edge. A partly loaded word therefore never reaches the converter, and several converters can be made to step together. Each channel also has a pending flag. The flag shows that the staging register has been written since the last commit.

Top module: `dac_dbuf`

## Requirements
- R1: An active-low asynchronous reset clears every staging register, every output register and every pending flag to zero.
- R2: A parallel write with `wr_mode` = 0 (full word) replaces the staging register of channel `wr_chan` with `wr_data`. The output register of that channel keeps its value.
- R3: A parallel write with `wr_mode` = 1 (byte) copies `wr_data[7:0]` into staging bits [8*L+7 : 8*L], where L is `wr_lane`. Bits that lie above the word width are dropped. Every other staging bit keeps its value.
- R4: A parallel write with `wr_mode` = 2 (nibble) copies `wr_data[3:0]` into staging bits [4*L+3 : 4*L]. Every other staging bit keeps its value.
- R5: While `sh_en` is high, the staging register of channel `sh_chan` shifts left by one bit per clock and takes `sh_bit` into bit 0. The first bit shifted in therefore ends at the MSB after WIDTH clocks.
- R6: The output registers change only on a clock edge at which `upd` is high. On that edge every channel's output register takes its staging value, all on the same cycle.
- R7: A channel's pending flag is set by any write or shift that reaches that channel's staging register. The flag stays set until an edge with `upd` high clears it.
- R8: When a write and `upd` fall on the same edge, the output register takes the staging value from before the write. The write then lands in the staging register, and the channel's pending flag ends set.
- R9: When a parallel write and a shift target the same channel on the same edge, the parallel write wins and the shift is dropped.
- R10: A write is ignored in three cases: a byte write whose lane starts at or above WIDTH, a nibble write whose lane starts at or above WIDTH, and any write with `wr_mode` = 3. An ignored write leaves the staging register and the pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Parallel write strobe |
| wr_mode | input | 2 | 0 full word, 1 byte, 2 nibble, 3 reserved |
| wr_chan | input | CH_W | Channel addressed by the parallel write |
| wr_lane | input | LANE_W | Byte or nibble lane index |
| wr_data | input | WIDTH | Write data, low bits used for partial writes |
| sh_en | input | 1 | Serial shift enable |
| sh_chan | input | CH_W | Channel addressed by the shift |
| sh_bit | input | 1 | Serial data bit, MSB first |
| upd | input | 1 | Commit strobe shared by all channels |
| staged | output | CHANNELS*WIDTH | Staging registers, channel c at bits [c*WIDTH +: WIDTH] |
| dac_out | output | CHANNELS*WIDTH | Output registers that drive the converters |
| pending | output | CHANNELS | Per-channel flag for uncommitted data |

## Verification
A write to the staging register and a commit can fall on the same edge. To provoke this, the bench raises `wr_en` and `upd` together in one cycle while the staging register already holds a known value. After that edge, three checks apply. The output register must show the earlier staging value. The staging register must show the newly written word. The written channel's pending flag must stay set, while the flag of every untouched channel is cleared.

// File: rtl/dac_dbuf.sv
module dac_dbuf #(
  parameter int WIDTH    = 12,
  parameter int CHANNELS = 2,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int NIB_N   = (WIDTH + 3) / 4,
  localparam int LANE_W  = (NIB_N > 1) ? $clog2(NIB_N) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_mode,
  input  logic [CH_W-1:0]              wr_chan,
  input  logic [LANE_W-1:0]            wr_lane,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         sh_en,
  input  logic [CH_W-1:0]              sh_chan,
  input  logic                         sh_bit,
  input  logic                         upd,
  output logic [CHANNELS*WIDTH-1:0]    staged,
  output logic [CHANNELS*WIDTH-1:0]    dac_out,
  output logic [CHANNELS-1:0]          pending
);

  localparam logic [1:0] M_WORD = 2'd0;
  localparam logic [1:0] M_BYTE = 2'd1;
  localparam logic [1:0] M_NIB  = 2'd2;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [WIDTH-1:0] stg_q, stg_d, out_q;
    logic             pend_q, touch;
    wire              hit_w = wr_en && (int'(wr_chan) == c);
    wire              hit_s = sh_en && (int'(sh_chan) == c) && !hit_w;

    always_comb begin
      stg_d = stg_q;
      touch = 1'b0;
      if (hit_w) begin
        case (wr_mode)
          M_WORD: begin
            stg_d = wr_data;
            touch = 1'b1;
          end
          M_BYTE: begin
            if (int'(wr_lane) * 8 < WIDTH) begin
              touch = 1'b1;
              for (int b = 0; b < WIDTH; b++)
                if (b / 8 == int'(wr_lane)) stg_d[b] = wr_data[b % 8];
            end
          end
          M_NIB: begin
            if (int'(wr_lane) * 4 < WIDTH) begin
              touch = 1'b1;
              for (int b = 0; b < WIDTH; b++)
                if (b / 4 == int'(wr_lane)) stg_d[b] = wr_data[b % 4];
            end
          end
          default: ;
        endcase
      end else if (hit_s) begin
        stg_d = {stg_q[WIDTH-2:0], sh_bit};
        touch = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q  <= '0;
        out_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        stg_q <= stg_d;
        if (upd) out_q <= stg_q;
        if (touch)    pend_q <= 1'b1;
        else if (upd) pend_q <= 1'b0;
      end
    end

    assign staged[c*WIDTH +: WIDTH]  = stg_q;
    assign dac_out[c*WIDTH +: WIDTH] = out_q;
    assign pending[c]                = pend_q;
  end

endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk #(
  parameter int WIDTH    = 12,
  parameter int CHANNELS = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      sh_en,
  input logic                      upd,
  input logic [CHANNELS*WIDTH-1:0] staged,
  input logic [CHANNELS*WIDTH-1:0] dac_out,
  input logic [CHANNELS-1:0]       pending
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (staged == '0 && dac_out == '0 && pending == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(dac_out));

  p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> dac_out == $past(staged));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en && !sh_en) |=> pending == '0);

  p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sh_en) |=> (pending & ~$past(pending)) == '0);

  p_stage_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sh_en) |=> $stable(staged));

endmodule

bind dac_dbuf dac_dbuf_chk #(.WIDTH(WIDTH), .CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sh_en(sh_en), .upd(upd),
  .staged(staged), .dac_out(dac_out), .pending(pending)
);

// File: tb/dac_dbuf_tb.sv
`timescale 1ns/1ps
module dac_dbuf_tb;
  localparam int W = 12;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en = 1'b0, sh_en = 1'b0, sh_bit = 1'b0, upd = 1'b0;
  logic [1:0]   wr_mode = 2'd0, wr_lane = 2'd0;
  logic         wr_chan = 1'b0, sh_chan = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [N*W-1:0] staged, dac_out;
  logic [N-1:0] pending;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_dbuf #(.WIDTH(W), .CHANNELS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_chan(wr_chan), .wr_lane(wr_lane), .wr_data(wr_data),
    .sh_en(sh_en), .sh_chan(sh_chan), .sh_bit(sh_bit), .upd(upd),
    .staged(staged), .dac_out(dac_out), .pending(pending)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] stg(int c);
    return staged[c*W +: W];
  endfunction
  function automatic logic [W-1:0] dac(int c);
    return dac_out[c*W +: W];
  endfunction

  task automatic cyc(bit we, bit ch, logic [1:0] md, logic [1:0] ln,
                     logic [W-1:0] d, bit se, bit sc, bit sb, bit up);
    @(negedge clk);
    wr_en = we; wr_chan = ch; wr_mode = md; wr_lane = ln; wr_data = d;
    sh_en = se; sh_chan = sc; sh_bit = sb; upd = up;
    @(negedge clk);
    wr_en = 0; sh_en = 0; upd = 0;
  endtask

  task automatic wr(bit ch, logic [1:0] md, logic [1:0] ln, logic [W-1:0] d);
    cyc(1, ch, md, ln, d, 0, 0, 0, 0);
  endtask
  task automatic commit();
    cyc(0, 0, 0, 0, '0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 staged", staged, 0);
    chk("R1 dac", dac_out, 0);
    chk("R1 pending", pending, 0);
  endtask

  task automatic t_full_and_commit();
    wr(0, 2'd0, 0, 12'hABC);
    chk("R2 staged0", stg(0), 12'hABC);
    chk("R2 dac0 held", dac(0), 0);
    chk("R7 pending set", pending, 2'b01);
    commit();
    chk("R6 dac0 commit", dac(0), 12'hABC);
    chk("R7 pending cleared", pending, 0);
    wr(1, 2'd0, 0, 12'h123);
    wr(0, 2'd0, 0, 12'h456);
    chk("R7 both pending", pending, 2'b11);
    chk("R6 dac held before commit", dac_out, {12'h000, 12'hABC});
    commit();
    chk("R6 both channels same edge", dac_out, {12'h123, 12'h456});
  endtask

  task automatic t_byte();
    wr(1, 2'd1, 0, 12'h05A);
    chk("R3 byte lane0", stg(1), 12'h15A);
    wr(1, 2'd1, 1, 12'h0F7);
    chk("R3 byte lane1 truncated", stg(1), 12'h75A);
    chk("R6 dac1 held after partials", dac(1), 12'h123);
  endtask

  task automatic t_nibble();
    wr(0, 2'd2, 2, 12'h009);
    chk("R4 nibble lane2", stg(0), 12'h956);
    wr(0, 2'd2, 1, 12'h00E);
    chk("R4 nibble lane1", stg(0), 12'h9E6);
    cyc(0, 0, 0, 0, '0, 0, 0, 0, 0);
    chk("R7 pending sticky", pending, 2'b11);
    commit();
    chk("R6 commit partials", dac_out, {12'h75A, 12'h9E6});
  endtask

  task automatic t_ignored();
    wr(0, 2'd1, 2, 12'hFFF);
    chk("R10 byte lane2 stage", stg(0), 12'h9E6);
    chk("R10 byte lane2 pending", pending, 0);
    wr(0, 2'd2, 3, 12'hFFF);
    chk("R10 nibble lane3 stage", stg(0), 12'h9E6);
    wr(0, 2'd3, 0, 12'hFFF);
    chk("R10 mode3 stage", stg(0), 12'h9E6);
    chk("R10 mode3 pending", pending, 0);
  endtask

  task automatic t_serial();
    logic [W-1:0] v = 12'hC3A;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, '0, 1, 1, v[W-1-i], 0);
    chk("R5 partial shift", stg(1), 12'h5AC);
    chk("R7 shift sets pending", pending, 2'b10);
    for (int i = 4; i < W; i++) cyc(0, 0, 0, 0, '0, 1, 1, v[W-1-i], 0);
    chk("R5 full shift msb first", stg(1), 12'hC3A);
    chk("R6 dac1 held during shift", dac(1), 12'h75A);
  endtask

  task automatic t_same_cycle();
    cyc(1, 0, 2'd0, 0, 12'h111, 0, 0, 0, 1);
    chk("R8 dac gets old stage", dac_out, {12'hC3A, 12'h9E6});
    chk("R8 write lands", stg(0), 12'h111);
    chk("R8 pending after", pending, 2'b01);
  endtask

  task automatic t_priority();
    cyc(1, 1, 2'd0, 0, 12'h0F0, 1, 1, 1, 0);
    chk("R9 write beats shift", stg(1), 12'h0F0);
    commit();
    chk("R6 final commit", dac_out, {12'h0F0, 12'h111});
    chk("R7 final pending", pending, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_full_and_commit();
    t_byte();
    t_nibble();
    t_ignored();
    t_serial();
    t_same_cycle();
    t_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule